// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

Two eight-line interrupt units, a master and a slave, are linked so that sixteen request lines share one processor interrupt. Each unit keeps a pending register, an in-service register and a mask register, and each line has its own edge or level trigger select. The slave resolves its own lines and presents one combined request to master line 2. When the processor acknowledges, the block returns an 8-bit vector and marks the winning line in service. Software later retires it with specific end-of-interrupt commands.

Priority is fully nested: a line may interrupt only if no line of equal or higher priority in its unit is in service. A slave line in service also holds master line 2 in service. That blocks master lines 3 to 7 and all further slave lines until both units receive their end-of-interrupt commands. A configuration write port sets masks, trigger modes and the two vector bases. A read port shows any register as one 16-bit word, with the master in the low byte and the slave in the high byte.

Top module: `cascade_pic`

## Requirements
- R1: A level-mode line's pending bit equals the line as sampled on the previous clock edge, whatever the mask and in-service bits hold. An edge-mode line's pending bit is set by a rising edge and stays set until that line is acknowledged, even if the line falls.
- R2: A masked line still shows as pending, but it does not assert int_o. Clearing its mask bit lets it assert int_o from the following cycle.
- R3: An in-service bit is set only by ack_i. An acknowledge marks the winning line and sets vec_o to the base of that line's unit plus its 3-bit index. The master base is written by cfg_wdata_i[7:0] and the slave base by cfg_wdata_i[15:8] with cfg_addr_i=2. The reset bases are 0x20 and 0x28.
- R4: An in-service bit is cleared only by an end-of-interrupt pulse on eoi_i. The command names the unit (eoi_slave_i, 1 = slave) and the line (eoi_line_i), and it clears only that bit.
- R5: int_o is high only when some unmasked pending master bit has no in-service bit at its own or a higher priority (a lower index).
- R6: Master pending bit 2 shows the slave's combined request, which is the slave's own form of R5. irq_lines_i[2] has no effect.
- R7: The effective priority, highest first, is line 0, 1, 8, 9 to 15, then 3, 4, 5, 6, 7.
- R8: Acknowledging a slave line sets both that slave in-service bit and master in-service bit 2. Until both are cleared, master lines 3 to 7 and every other slave line do not raise int_o.
- R9: rd_sel_i selects the 16-bit read word: 0 pending, 1 in-service, 2 mask, 3 trigger mode. Bit n is line n. The mask is written with cfg_addr_i=0 and the mode with cfg_addr_i=1, where a mode bit of 1 means level.
- R10: Switching a line from edge to level mode while the line is high makes it pending on the next cycle, even if its edge was already consumed.
- R11: An acknowledge with no eligible request returns the master base plus 7 and changes no in-service bit.
- R12: After reset, all pending, in-service, mask and mode bits are 0, int_o is 0 and vec_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 16 | Request lines; 7:0 master, 15:8 slave |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | 0 mask, 1 mode, 2 vector bases |
| cfg_wdata_i | input | 16 | Configuration write data |
| rd_sel_i | input | 2 | Read word select |
| rd_data_o | output | 16 | Selected register word |
| int_o | output | 1 | Processor interrupt request |
| ack_i | input | 1 | Acknowledge pulse |
| vec_o | output | 8 | Vector returned by the last acknowledge |
| eoi_i | input | 1 | End-of-interrupt pulse |
| eoi_slave_i | input | 1 | End-of-interrupt target unit, 1 = slave |
| eoi_line_i | input | 3 | End-of-interrupt target line |

## Verification
The assertions assume that ack_i and eoi_i are single-cycle pulses sampled on the clock, and that the request lines are low when reset is released, so no false edge is seen at start-up. The stimulus changes inputs only just after a clock edge. It holds each line for at least one full cycle and never raises ack_i and eoi_i together. The only state the block sees from software is the mask, mode and base writes, and end-of-interrupt commands always name a bit that is in service or is deliberately wrong.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned LINES     = 8;
  localparam int unsigned IDX_W     = $clog2(LINES);
  localparam int unsigned WORD_W    = 2 * LINES;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned CASC_LINE = 2;
  localparam logic [VEC_W-1:0] MBASE_RST = 8'h20;
  localparam logic [VEC_W-1:0] SBASE_RST = 8'h28;

  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_MODE = 2'd1,
    CFG_BASE = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    RD_PEND = 2'd0,
    RD_INSV = 2'd1,
    RD_MASK = 2'd2,
    RD_MODE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/pic_trig.sv
module pic_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic level_i,
  input  logic clr_i,
  output logic pend_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      line_q <= line_i;
      if (level_i) pend_o <= line_i;
      else         pend_o <= (pend_o & ~clr_i) | (line_i & ~line_q);
    end
  end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isr_i,
  output logic          req_o,
  output logic [IW-1:0] idx_o
);
  logic blk;

  // lowest index wins; an in-service bit blocks itself and everything below
  always_comb begin
    req_o = 1'b0;
    idx_o = '0;
    blk   = 1'b0;
    for (int i = 0; i < N; i++) begin
      blk = blk | isr_i[i];
      if (!blk && !req_o && pend_i[i]) begin
        req_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter bit          HAS_CASC = 1'b0,
  parameter int unsigned CASC_IDX = CASC_LINE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  input  logic             casc_i,
  input  logic             mask_we_i,
  input  logic [LINES-1:0] mask_d_i,
  input  logic             mode_we_i,
  input  logic [LINES-1:0] mode_d_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] take_idx_i,
  input  logic             eoi_i,
  input  logic [IDX_W-1:0] eoi_idx_i,
  output logic             req_o,
  output logic [IDX_W-1:0] win_o,
  output logic [LINES-1:0] irr_o,
  output logic [LINES-1:0] isr_o,
  output logic [LINES-1:0] imr_o,
  output logic [LINES-1:0] mode_o
);
  logic [LINES-1:0] irr, isr_q, isr_d, imr_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q  <= '0;
      mode_q <= '0;
      isr_q  <= '0;
    end else begin
      if (mask_we_i) imr_q  <= mask_d_i;
      if (mode_we_i) mode_q <= mode_d_i;
      isr_q <= isr_d;
    end
  end

  always_comb begin
    isr_d = isr_q;
    if (eoi_i)  isr_d[eoi_idx_i]  = 1'b0;
    if (take_i) isr_d[take_idx_i] = 1'b1;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    if (HAS_CASC && g == CASC_IDX) begin : g_casc
      logic unused_line;
      assign unused_line = line_i[g];
      assign irr[g] = casc_i;
    end else begin : g_trig
      pic_trig u_trig (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (line_i[g]),
        .level_i(mode_q[g]),
        .clr_i  (take_i && (take_idx_i == IDX_W'(g))),
        .pend_o (irr[g])
      );
    end
  end

  if (!HAS_CASC) begin : g_nocasc
    logic unused_casc;
    assign unused_casc = casc_i;
  end

  pic_resolve #(.N(LINES), .IW(IDX_W)) u_res (
    .pend_i(irr & ~imr_q),
    .isr_i (isr_q),
    .req_o (req_o),
    .idx_o (win_o)
  );

  assign irr_o  = irr;
  assign isr_o  = isr_q;
  assign imr_o  = imr_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
  import pic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] irq_lines_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic [1:0]        rd_sel_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              int_o,
  input  logic              ack_i,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              eoi_i,
  input  logic              eoi_slave_i,
  input  logic [IDX_W-1:0]  eoi_line_i
);
  localparam int unsigned PAD_W = VEC_W - IDX_W;

  logic             m_req, s_req, m_take, s_take;
  logic [IDX_W-1:0] m_win, s_win;
  logic [LINES-1:0] m_irr, m_isr, m_imr, m_mode;
  logic [LINES-1:0] s_irr, s_isr, s_imr, s_mode;
  logic [VEC_W-1:0] m_base_q, s_base_q;
  logic             mask_we, mode_we, base_we;
  logic [WORD_W-1:0] irr_word, isr_word, imr_word, mode_word;

  assign mask_we = cfg_we_i && (cfg_sel_e'(cfg_addr_i) == CFG_MASK);
  assign mode_we = cfg_we_i && (cfg_sel_e'(cfg_addr_i) == CFG_MODE);
  assign base_we = cfg_we_i && (cfg_sel_e'(cfg_addr_i) == CFG_BASE);

  assign m_take = ack_i && m_req;
  assign s_take = m_take && (m_win == IDX_W'(CASC_LINE));

  pic_unit #(.HAS_CASC(1'b1), .CASC_IDX(CASC_LINE)) u_master (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (irq_lines_i[LINES-1:0]),
    .casc_i    (s_req),
    .mask_we_i (mask_we),
    .mask_d_i  (cfg_wdata_i[LINES-1:0]),
    .mode_we_i (mode_we),
    .mode_d_i  (cfg_wdata_i[LINES-1:0]),
    .take_i    (m_take),
    .take_idx_i(m_win),
    .eoi_i     (eoi_i && !eoi_slave_i),
    .eoi_idx_i (eoi_line_i),
    .req_o     (m_req),
    .win_o     (m_win),
    .irr_o     (m_irr),
    .isr_o     (m_isr),
    .imr_o     (m_imr),
    .mode_o    (m_mode)
  );

  pic_unit #(.HAS_CASC(1'b0), .CASC_IDX(CASC_LINE)) u_slave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (irq_lines_i[WORD_W-1:LINES]),
    .casc_i    (1'b0),
    .mask_we_i (mask_we),
    .mask_d_i  (cfg_wdata_i[WORD_W-1:LINES]),
    .mode_we_i (mode_we),
    .mode_d_i  (cfg_wdata_i[WORD_W-1:LINES]),
    .take_i    (s_take),
    .take_idx_i(s_win),
    .eoi_i     (eoi_i && eoi_slave_i),
    .eoi_idx_i (eoi_line_i),
    .req_o     (s_req),
    .win_o     (s_win),
    .irr_o     (s_irr),
    .isr_o     (s_isr),
    .imr_o     (s_imr),
    .mode_o    (s_mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_base_q <= MBASE_RST;
      s_base_q <= SBASE_RST;
      vec_o    <= '0;
    end else begin
      if (base_we) begin
        m_base_q <= cfg_wdata_i[VEC_W-1:0];
        s_base_q <= cfg_wdata_i[2*VEC_W-1:VEC_W];
      end
      if (ack_i) begin
        if (!m_req)      vec_o <= m_base_q + VEC_W'(LINES - 1);
        else if (s_take) vec_o <= s_base_q + {{PAD_W{1'b0}}, s_win};
        else             vec_o <= m_base_q + {{PAD_W{1'b0}}, m_win};
      end
    end
  end

  assign irr_word  = {s_irr, m_irr};
  assign isr_word  = {s_isr, m_isr};
  assign imr_word  = {s_imr, m_imr};
  assign mode_word = {s_mode, m_mode};

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      RD_PEND: rd_data_o = irr_word;
      RD_INSV: rd_data_o = isr_word;
      RD_MASK: rd_data_o = imr_word;
      default: rd_data_o = mode_word;
    endcase
  end

  assign int_o = m_req;
endmodule

// File: rtl/cascade_pic_chk.sv
module cascade_pic_chk
  import pic_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              eoi_i,
  input logic              int_o,
  input logic [WORD_W-1:0] irr_w,
  input logic [WORD_W-1:0] isr_w,
  input logic [WORD_W-1:0] imr_w
);
  // R3
  isr_set_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(isr_w & ~$past(isr_w))) |-> $past(ack_i));

  // R4
  isr_clr_on_eoi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~isr_w & $past(isr_w))) |-> $past(eoi_i));

  // R3
  one_master_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_w[LINES-1:0] & ~$past(isr_w[LINES-1:0])) <= 1);

  // R2
  int_needs_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|(irr_w[LINES-1:0] & ~imr_w[LINES-1:0])));

  // R8
  slave_holds_casc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(isr_w[WORD_W-1:LINES] & ~$past(isr_w[WORD_W-1:LINES]))) |-> isr_w[CASC_LINE]);
endmodule

bind cascade_pic cascade_pic_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ack_i (ack_i),
  .eoi_i (eoi_i),
  .int_o (int_o),
  .irr_w (irr_word),
  .isr_w (isr_word),
  .imr_w (imr_word)
);

// File: tb/cascade_pic_tb.sv
module cascade_pic_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {lines, expected vector}; 8'hFF means no interrupt expected
  localparam logic [23:0] VEC_TBL [NVEC] = '{
    {16'h0003, 8'h20}, {16'h0002, 8'h21}, {16'h0108, 8'h28},
    {16'h8008, 8'h2F}, {16'h00F0, 8'h24}, {16'h0A00, 8'h29},
    {16'h0080, 8'h27}, {16'h0004, 8'hFF}, {16'h4002, 8'h21},
    {16'h00E8, 8'h23}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_lines_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic [15:0] rd_data_o;
  logic        int_o;
  logic        ack_i = 1'b0;
  logic [7:0]  vec_o;
  logic        eoi_i = 1'b0;
  logic        eoi_slave_i = 1'b0;
  logic [2:0]  eoi_line_i = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cascade_pic u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_lines_i(irq_lines_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .int_o(int_o),
    .ack_i(ack_i), .vec_o(vec_o), .eoi_i(eoi_i),
    .eoi_slave_i(eoi_slave_i), .eoi_line_i(eoi_line_i)
  );

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    rd_sel_i = sel;
    #1;
    v = rd_data_o;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
  endtask

  task automatic eoi(input logic sl, input logic [2:0] ln);
    eoi_i = 1'b1; eoi_slave_i = sl; eoi_line_i = ln;
    step();
    eoi_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) step();
    rst_ni = 1'b1;
    step();

    // R12 reset state
    chk("R12 int", {15'd0, int_o}, 16'd0);
    chk("R12 vec", {8'd0, vec_o}, 16'd0);
    rd(0, v); chk("R12 pend", v, 16'h0000);
    rd(1, v); chk("R12 isr", v, 16'h0000);
    rd(2, v); chk("R12 mask", v, 16'h0000);
    rd(3, v); chk("R12 mode", v, 16'h0000);

    // R7 priority table, all lines level mode
    cfg(1, 16'hFFFF);
    for (int k = 0; k < NVEC; k++) begin
      irq_lines_i = VEC_TBL[k][23:8];
      step(); step();
      if (VEC_TBL[k][7:0] == 8'hFF) begin
        chk("R6 line2 ignored", {15'd0, int_o}, 16'd0);
      end else begin
        chk("R7 int", {15'd0, int_o}, 16'd1);
        ack();
        chk("R7 vector", {8'd0, vec_o}, {8'd0, VEC_TBL[k][7:0]});
        if (VEC_TBL[k][7:0] >= 8'h28) begin
          eoi(1'b1, 3'(VEC_TBL[k][7:0] - 8'h28));
          eoi(1'b0, 3'd2);
        end else begin
          eoi(1'b0, 3'(VEC_TBL[k][7:0] - 8'h20));
        end
      end
      irq_lines_i = '0;
      step();
      rd(1, v); chk("R4 isr clear", v, 16'h0000);
    end

    // R3 programmable bases
    cfg(2, 16'h4030);
    irq_lines_i = 16'h0200; step(); step(); ack();
    chk("R3 slave base", {8'd0, vec_o}, 16'h0041);
    eoi(1'b1, 3'd1); eoi(1'b0, 3'd2);
    irq_lines_i = 16'h0002; step(); step(); ack();
    chk("R3 master base", {8'd0, vec_o}, 16'h0031);
    eoi(1'b0, 3'd1);
    irq_lines_i = '0;
    cfg(2, 16'h2820);
    cfg(1, 16'h0000);
    step();

    // R1 edge latching
    irq_lines_i[5] = 1'b1; step();
    irq_lines_i[5] = 1'b0; step(); step();
    rd(0, v); chk("R1 edge latched", v, 16'h0020);
    ack();
    chk("R3 vector", {8'd0, vec_o}, 16'h0025);
    rd(0, v); chk("R1 edge cleared by ack", v, 16'h0000);
    rd(1, v); chk("R3 isr set", v, 16'h0020);
    eoi(1'b0, 3'd4); rd(1, v); chk("R4 wrong line", v, 16'h0020);
    eoi(1'b1, 3'd5); rd(1, v); chk("R4 wrong unit", v, 16'h0020);
    eoi(1'b0, 3'd5); rd(1, v); chk("R4 cleared", v, 16'h0000);

    // R2 masking
    cfg(0, 16'h0008);
    irq_lines_i[3] = 1'b1; step(); step();
    rd(0, v); chk("R2 masked pending", v, 16'h0008);
    chk("R2 masked no int", {15'd0, int_o}, 16'd0);
    cfg(0, 16'h0000);
    chk("R2 unmasked int", {15'd0, int_o}, 16'd1);
    ack();
    chk("R2 vector", {8'd0, vec_o}, 16'h0023);

    // R5 nesting: isr3 blocks 4, not 1
    irq_lines_i[4] = 1'b1; step(); step();
    chk("R5 blocked", {15'd0, int_o}, 16'd0);
    irq_lines_i[1] = 1'b1; step(); step();
    chk("R5 higher passes", {15'd0, int_o}, 16'd1);
    ack();
    chk("R5 vector", {8'd0, vec_o}, 16'h0021);
    eoi(1'b0, 3'd1); eoi(1'b0, 3'd3);
    chk("R5 unblocked", {15'd0, int_o}, 16'd1);
    ack();
    chk("R5 vector 4", {8'd0, vec_o}, 16'h0024);
    eoi(1'b0, 3'd4);
    irq_lines_i = '0; step();
    rd(1, v); chk("R5 isr clear", v, 16'h0000);

    // R8 cascade hold
    irq_lines_i[10] = 1'b1; step(); step(); ack();
    chk("R8 vector", {8'd0, vec_o}, 16'h002A);
    rd(1, v); chk("R8 both isr", v, 16'h0404);
    irq_lines_i[3] = 1'b1; irq_lines_i[8] = 1'b1; step(); step();
    chk("R8 blocked", {15'd0, int_o}, 16'd0);
    eoi(1'b1, 3'd2);
    rd(1, v); chk("R8 master held", v, 16'h0004);
    chk("R8 still blocked", {15'd0, int_o}, 16'd0);
    eoi(1'b0, 3'd2);
    chk("R8 released", {15'd0, int_o}, 16'd1);
    ack();
    chk("R8 slave wins", {8'd0, vec_o}, 16'h0028);
    eoi(1'b1, 3'd0); eoi(1'b0, 3'd2);
    ack();
    chk("R8 then line3", {8'd0, vec_o}, 16'h0023);
    eoi(1'b0, 3'd3);
    irq_lines_i = '0; step();

    // R10 mode switch creates request
    irq_lines_i[6] = 1'b1; step(); step(); ack();
    chk("R10 vector", {8'd0, vec_o}, 16'h0026);
    eoi(1'b0, 3'd6);
    rd(0, v); chk("R10 consumed", v, 16'h0000);
    cfg(1, 16'h0040); step();
    rd(0, v); chk("R10 level pending", v, 16'h0040);
    chk("R10 int", {15'd0, int_o}, 16'd1);
    irq_lines_i = '0; step(); step();
    rd(0, v); chk("R1 level follows", v, 16'h0000);
    rd(3, v); chk("R9 mode read", v, 16'h0040);
    cfg(1, 16'h0000);

    // R11 spurious
    ack();
    chk("R11 vector", {8'd0, vec_o}, 16'h0027);
    rd(1, v); chk("R11 no isr", v, 16'h0000);

    // R9 read port
    cfg(0, 16'h1234); rd(2, v); chk("R9 mask read", v, 16'h1234);
    cfg(1, 16'h8001); rd(3, v); chk("R9 mode read", v, 16'h8001);
    cfg(0, 16'h0000); cfg(1, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule